// File: doc/BRIEF.md
# Hysteretic Valley-Lockout Mode Selector

This block chooses the operating mode of a quasi-resonant flyback controller from a digitized feedback level. There are five modes: turn-on in the first, second, third or fourth valley of the drain ringing, or a variable-frequency mode for very light load. Each boundary between two neighbouring modes has a lower threshold used while feedback falls and a higher one used while it rises. The chosen valley therefore stays locked until the load moves by a clear margin.

Alongside the mode, the block produces a peak-current setpoint in the millivolt scale of the current-sense input. It also raises a flag that pins the frequency-setting ramp threshold at its ceiling when feedback is very low. One feedback sample is taken per clock, and every output is registered one clock after the sample it reflects.

Top module: `valley_mode_sel`

## Requirements
- R1: While rst_ni is low, the outputs are valley_o = 1, vco_o = 0, ipk_mv_o = 800 and ct_clamp_o = 0.
- R2: With feedback falling, the selector moves one valley deeper when the sample is strictly below the boundary threshold. Valley 1 goes to 2 below 1400 mV, 2 goes to 3 below 1200 mV, and 3 goes to 4 below 900 mV. The new state shows on the outputs one clock after the sample.
- R3: In valley 4, a sample strictly below 800 mV selects the variable-frequency mode. That mode is encoded as vco_o = 1 with valley_o = 0. In every valley mode, vco_o = 0 and valley_o holds the valley number, 1 to 4.
- R4: With feedback rising, the selector moves one valley shallower when the sample is strictly above the boundary threshold. The variable-frequency mode goes to valley 4 above 1400 mV, 4 goes to 3 above 1600 mV, 3 goes to 2 above 1800 mV, and 2 goes to 1 above 2000 mV.
- R5: A sample that lies between the falling and rising thresholds of the current mode leaves the mode unchanged. A sample exactly equal to a threshold also leaves the mode unchanged.
- R6: The mode moves by at most one step per sample. A large jump in feedback walks through the intermediate modes on successive clocks.
- R7: ipk_mv_o equals the sample divided by 4, rounded down, when that quotient lies between 140 and 800 mV.
- R8: ipk_mv_o never falls below 140 mV, which is 17.5 % of the 800 mV maximum. Any sample below 560 mV gives exactly 140.
- R9: ipk_mv_o never exceeds 800 mV. Any sample of 3204 mV or more gives exactly 800.
- R10: ct_clamp_o is 1 one clock after a sample strictly below 300 mV, and 0 one clock after any other sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one feedback sample per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_mv_i | input | 12 | Feedback sample, unsigned millivolts |
| valley_o | output | 3 | Selected valley 1 to 4, or 0 in variable-frequency mode |
| vco_o | output | 1 | Variable-frequency mode active |
| ipk_mv_o | output | 12 | Peak-current setpoint, millivolts on the current-sense scale |
| ct_clamp_o | output | 1 | Hold the frequency-setting threshold at its maximum |

## Verification
The assertions assume that fb_mv_i is stable and known at every rising edge. They also assume that reset is applied from time zero, so that no history is taken from before reset. The bench changes the feedback only on falling edges and holds reset low from the first instant. Its sample sequences sit exactly on each threshold and one millivolt beyond it in both directions. They also include full-scale jumps that force the one-step-per-sample walk, and setpoint values at the floor, the cap and in the linear region.

// File: rtl/vms_pkg.sv
package vms_pkg;
  typedef enum logic [2:0] {
    MODE_V1  = 3'd0,
    MODE_V2  = 3'd1,
    MODE_V3  = 3'd2,
    MODE_V4  = 3'd3,
    MODE_VCO = 3'd4
  } mode_e;

  localparam int NUM_BOUND = 4;
endpackage

// File: rtl/vms_mode_fsm.sv
module vms_mode_fsm
  import vms_pkg::*;
#(
  parameter int FB_W = 12,
  // boundary b separates mode b and mode b+1; lowest slice = boundary 0
  parameter logic [NUM_BOUND*FB_W-1:0] FALL_MV = {12'd800, 12'd900, 12'd1200, 12'd1400},
  parameter logic [NUM_BOUND*FB_W-1:0] RISE_MV = {12'd1400, 12'd1600, 12'd1800, 12'd2000}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_i,
  output mode_e           mode_o
);
  logic [NUM_BOUND-1:0] below;
  logic [NUM_BOUND-1:0] above;
  mode_e mode_q, mode_n;

  for (genvar b = 0; b < NUM_BOUND; b++) begin : g_bound
    assign below[b] = fb_i < FALL_MV[b*FB_W +: FB_W];
    assign above[b] = fb_i > RISE_MV[b*FB_W +: FB_W];
  end

  always_comb begin
    mode_n = mode_q;
    unique case (mode_q)
      MODE_V1: if (below[0]) mode_n = MODE_V2;
      MODE_V2: begin
        if (below[1])      mode_n = MODE_V3;
        else if (above[0]) mode_n = MODE_V1;
      end
      MODE_V3: begin
        if (below[2])      mode_n = MODE_V4;
        else if (above[1]) mode_n = MODE_V2;
      end
      MODE_V4: begin
        if (below[3])      mode_n = MODE_VCO;
        else if (above[2]) mode_n = MODE_V3;
      end
      MODE_VCO: if (above[3]) mode_n = MODE_V4;
      default:  mode_n = MODE_V1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_V1;
    else         mode_q <= mode_n;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vms_setpoint.sv
module vms_setpoint #(
  parameter int FB_W        = 12,
  parameter int IPK_MAX_MV  = 800,
  parameter int IPK_MIN_MV  = 140,
  parameter int CT_CLAMP_MV = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_i,
  output logic [FB_W-1:0] ipk_o,
  output logic            ct_clamp_o
);
  localparam logic [FB_W-1:0] MAX_C   = FB_W'(IPK_MAX_MV);
  localparam logic [FB_W-1:0] MIN_C   = FB_W'(IPK_MIN_MV);
  localparam logic [FB_W-1:0] CLAMP_C = FB_W'(CT_CLAMP_MV);

  logic [FB_W-1:0] quarter;
  logic [FB_W-1:0] ipk_n;

  assign quarter = {2'b00, fb_i[FB_W-1:2]};

  always_comb begin
    if (quarter > MAX_C)      ipk_n = MAX_C;
    else if (quarter < MIN_C) ipk_n = MIN_C;   // frozen floor
    else                      ipk_n = quarter;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipk_o      <= MAX_C;
      ct_clamp_o <= 1'b0;
    end else begin
      ipk_o      <= ipk_n;
      ct_clamp_o <= fb_i < CLAMP_C;
    end
  end
endmodule

// File: rtl/vms_decode.sv
module vms_decode
  import vms_pkg::*;
(
  input  mode_e       mode_i,
  output logic [2:0]  valley_o,
  output logic        vco_o
);
  always_comb begin
    vco_o    = (mode_i == MODE_VCO);
    valley_o = vco_o ? 3'd0 : 3'(mode_i) + 3'd1;
  end
endmodule

// File: rtl/valley_mode_sel.sv
module valley_mode_sel
  import vms_pkg::*;
#(
  parameter int FB_W        = 12,
  parameter logic [NUM_BOUND*FB_W-1:0] FALL_MV = {12'd800, 12'd900, 12'd1200, 12'd1400},
  parameter logic [NUM_BOUND*FB_W-1:0] RISE_MV = {12'd1400, 12'd1600, 12'd1800, 12'd2000},
  parameter int IPK_MAX_MV  = 800,
  parameter int FLOOR_PERMIL = 175,
  parameter int CT_CLAMP_MV = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_mv_i,
  output logic [2:0]      valley_o,
  output logic            vco_o,
  output logic [FB_W-1:0] ipk_mv_o,
  output logic            ct_clamp_o
);
  localparam int IPK_MIN_MV = IPK_MAX_MV * FLOOR_PERMIL / 1000;

  mode_e mode;

  vms_mode_fsm #(
    .FB_W   (FB_W),
    .FALL_MV(FALL_MV),
    .RISE_MV(RISE_MV)
  ) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fb_i  (fb_mv_i),
    .mode_o(mode)
  );

  vms_decode u_dec (
    .mode_i  (mode),
    .valley_o(valley_o),
    .vco_o   (vco_o)
  );

  vms_setpoint #(
    .FB_W       (FB_W),
    .IPK_MAX_MV (IPK_MAX_MV),
    .IPK_MIN_MV (IPK_MIN_MV),
    .CT_CLAMP_MV(CT_CLAMP_MV)
  ) u_set (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fb_i      (fb_mv_i),
    .ipk_o     (ipk_mv_o),
    .ct_clamp_o(ct_clamp_o)
  );
endmodule

// File: rtl/vms_checker.sv
module vms_checker #(
  parameter int FB_W        = 12,
  parameter int FALL_TOP    = 1400,
  parameter int RISE_LOW    = 1400,
  parameter int IPK_MAX_MV  = 800,
  parameter int IPK_MIN_MV  = 140,
  parameter int CT_CLAMP_MV = 300
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [FB_W-1:0] fb_mv_i,
  input logic [2:0]      valley_o,
  input logic            vco_o,
  input logic [FB_W-1:0] ipk_mv_o,
  input logic            ct_clamp_o
);
  localparam logic [FB_W-1:0] FALL_C  = FB_W'(FALL_TOP);
  localparam logic [FB_W-1:0] RISE_C  = FB_W'(RISE_LOW);
  localparam logic [FB_W-1:0] MAX_C   = FB_W'(IPK_MAX_MV);
  localparam logic [FB_W-1:0] MIN_C   = FB_W'(IPK_MIN_MV);
  localparam logic [FB_W-1:0] FRZ_C   = FB_W'(4 * IPK_MIN_MV);
  localparam logic [FB_W-1:0] CLAMP_C = FB_W'(CT_CLAMP_MV);

  logic [2:0] idx;
  assign idx = vco_o ? 3'd5 : valley_o;

  assert_one_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((idx >= $past(idx)) ? (idx - $past(idx)) : ($past(idx) - idx)) <= 3'd1);

  assert_hold_v1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valley_o == 3'd1 && fb_mv_i >= FALL_C) |=> valley_o == 3'd1);

  assert_hold_vco_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vco_o && fb_mv_i <= RISE_C) |=> vco_o);

  assert_vco_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vco_o) |-> $past(valley_o) == 3'd4);

  assert_vco_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_o == (valley_o == 3'd0));

  assert_ipk_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipk_mv_o >= MIN_C && ipk_mv_o <= MAX_C);

  assert_ipk_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_mv_i < FRZ_C) |=> ipk_mv_o == MIN_C);

  assert_clamp_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_mv_i < CLAMP_C) |=> ct_clamp_o);

  assert_clamp_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_mv_i >= CLAMP_C) |=> !ct_clamp_o);
endmodule

bind valley_mode_sel vms_checker #(
  .FB_W       (FB_W),
  .FALL_TOP   (int'(FALL_MV[FB_W-1:0])),
  .RISE_LOW   (int'(RISE_MV[4*FB_W-1 -: FB_W])),
  .IPK_MAX_MV (IPK_MAX_MV),
  .IPK_MIN_MV (IPK_MIN_MV),
  .CT_CLAMP_MV(CT_CLAMP_MV)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fb_mv_i   (fb_mv_i),
  .valley_o  (valley_o),
  .vco_o     (vco_o),
  .ipk_mv_o  (ipk_mv_o),
  .ct_clamp_o(ct_clamp_o)
);

// File: tb/valley_mode_sel_test.sv
module valley_mode_sel_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] fb = '0;
  logic [2:0]  valley;
  logic        vco;
  logic [11:0] ipk;
  logic        ct_clamp;

  int checks = 0;
  int errors = 0;
  int mode   = 0;   // model: 0..3 = valley 1..4, 4 = variable frequency
  int e_ipk  = 800;
  bit e_clamp = 0;

  valley_mode_sel uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .fb_mv_i   (fb),
    .valley_o  (valley),
    .vco_o     (vco),
    .ipk_mv_o  (ipk),
    .ct_clamp_o(ct_clamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int next_mode(int m, int v);
    int fall[4] = '{1400, 1200, 900, 800};
    int rise[4] = '{2000, 1800, 1600, 1400};
    if (m < 4 && v < fall[m]) return m + 1;
    if (m > 0 && v > rise[m-1]) return m - 1;
    return m;
  endfunction

  task automatic compare(string tag);
    int  ev = (mode == 4) ? 0 : mode + 1;
    bit  evco = (mode == 4);
    checks++;
    if (valley !== 3'(ev) || vco !== evco || ipk !== 12'(e_ipk) || ct_clamp !== e_clamp) begin
      errors++;
      $display("FAIL %s: valley=%0d vco=%0d ipk=%0d clamp=%0d expected valley=%0d vco=%0d ipk=%0d clamp=%0d",
               tag, valley, vco, ipk, ct_clamp, ev, evco, e_ipk, e_clamp);
    end
  endtask

  task automatic step(int v, string tag);
    fb = 12'(v);
    @(posedge clk);
    mode = next_mode(mode, v);
    e_ipk = v / 4;
    if (e_ipk > 800) e_ipk = 800;
    if (e_ipk < 140) e_ipk = 140;
    e_clamp = (v < 300);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2 falling boundaries, exact threshold holds (R5)
    step(2500, "R9"); step(1400, "R5"); step(1399, "R2");
    step(1200, "R5"); step(1199, "R2");
    step(900, "R5");  step(899, "R2");
    // R3 entry into variable-frequency mode
    step(800, "R5");  step(799, "R3"); step(700, "R3");
    // R4 rising boundaries
    step(1400, "R5"); step(1401, "R4");
    step(1600, "R5"); step(1601, "R4");
    step(1800, "R5"); step(1801, "R4");
    step(2000, "R5"); step(2001, "R4");
    // R5 hysteresis band in valley 2
    step(1300, "R2"); step(1950, "R5"); step(1250, "R5");
    // R6 large jumps walk one mode per sample
    step(4095, "R6");
    for (int i = 0; i < 5; i++) step(100, "R6");
    for (int i = 0; i < 5; i++) step(4095, "R6");
    // R7 linear setpoint, R8 floor, R9 cap
    step(2003, "R7"); step(3199, "R7"); step(2401, "R7");
    step(3204, "R9"); step(3203, "R7");
    step(563, "R7");  step(560, "R8"); step(559, "R8"); step(0, "R8");
    // R10 clamp flag edges
    step(299, "R10"); step(300, "R10"); step(301, "R10"); step(1, "R10");
    step(2500, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule